// File: doc/BRIEF.md
# Thermal Sample Scheduler and Averager

This block sets the pace at which an on-die temperature sensor is read. A programmable interval timer sends the sensor a one-cycle request each time the interval expires. Each result that comes back passes through a recursive averager with a fixed weight of one half. This averager damps the short-term jitter of hot-spot readings. The averager is on after reset and can be switched off, so that raw readings pass straight through. The result is held in an output register, and a fresh-data flag tells a polling host that a new value is waiting. Because of the averaging, the host may poll more slowly than the sensor samples.

Software writes a configuration word with a single strobe. The word holds an interval in microseconds and a filter enable. The interval is clamped to the range 82 µs to 20 ms. It is turned into a clock-cycle count from the clock-frequency parameter and is loaded each time the interval restarts. The sensor is modelled as a request/valid handshake with signed 16-bit results.

Top module: `therm_sample_sched`

## Requirements
- R1: After reset, `sens_req`, `fresh` and `temp_out` are 0. The interval is 82 µs and the averager is enabled until the first configuration write.
- R2: With a prompt sensor, requests are one-cycle pulses, spaced exactly interval_us × (CLK_HZ / 1,000,000) cycles apart.
- R3: On a write, an interval below 82 is stored as 82, and an interval above 20000 is stored as 20000.
- R4: No request is issued while a sample is pending. If the interval has expired while a sample is pending, the next request goes out in the cycle after the pending sample is accepted. A sample accepted in the edge of cycle k therefore gives a request in cycle k+1.
- R5: A new interval takes effect only at the next request. The interval already running keeps its old length.
- R6: When the averager is enabled and primed, the new output is (previous + new) >>> 1. The sum is computed at 17 bits, so it cannot overflow, and the shift rounds toward negative infinity.
- R7: The first accepted sample after reset, or after the averager has been disabled and enabled again, is loaded unchanged.
- R8: When the averager is disabled, each accepted sample appears unchanged on `temp_out` one cycle after it is accepted.
- R9: `fresh` is set on every output update and cleared by `host_rd`. If an update and `host_rd` fall in the same cycle, `fresh` stays set.
- R10: A `sens_valid` that arrives while no request is pending is ignored. `temp_out` and `fresh` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Strobe that loads the configuration word |
| cfg_itv_us | input | 16 | Requested interval in microseconds, unsigned |
| cfg_filt_en | input | 1 | 1 enables the averager, 0 bypasses it |
| sens_req | output | 1 | One-cycle sample request to the sensor |
| sens_valid | input | 1 | Sensor result strobe |
| sens_temp | input | 16 | Sensor result, signed two's complement |
| host_rd | input | 1 | Host read strobe that clears `fresh` |
| temp_out | output | 16 | Held result, filtered or raw, signed |
| fresh | output | 1 | Set when `temp_out` holds an unread value |

## Verification
The averager is driven with three kinds of sequence. Mixed-sign values with odd sums separate floor rounding from truncation toward zero. Repeated full-scale positive and negative values expose any overflow in a 16-bit sum. A disable/enable cycle shows whether the state is reloaded or blended with a stale value. The timer is driven with sensors that answer both faster and slower than the interval, which separates a counter that stalls from one that keeps free-running. Interval writes at the low and high limits and in the middle of a period show whether clamping and the deferred load both work.

// File: rtl/therm_pkg.sv
package therm_pkg;

    localparam int TEMP_W = 16;
    localparam int US_W   = 16;
    localparam int MIN_US = 82;
    localparam int MAX_US = 20000;

    typedef logic signed [TEMP_W-1:0] temp_t;

    typedef struct packed {
        logic [US_W-1:0] itv_us;
        logic            filt_en;
    } sched_cfg_t;

    function automatic logic [US_W-1:0] clamp_us(input logic [US_W-1:0] us);
        if (int'(us) < MIN_US)
            return US_W'(MIN_US);
        else if (int'(us) > MAX_US)
            return US_W'(MAX_US);
        else
            return us;
    endfunction

    // Half-weight blend: 17-bit sum, arithmetic shift gives floor
    function automatic temp_t half_blend(input temp_t a, input temp_t b);
        logic signed [TEMP_W:0] sum;
        sum = {a[TEMP_W-1], a} + {b[TEMP_W-1], b};
        return sum[TEMP_W:1];
    endfunction

endpackage

// File: rtl/therm_cfg_reg.sv
module therm_cfg_reg
    import therm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [US_W-1:0]     itv_in,
    input  logic                en_in,
    output sched_cfg_t          cfg_o
);
    sched_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.itv_us  <= US_W'(MIN_US);
            cfg_q.filt_en <= 1'b1;
        end else if (wr) begin
            cfg_q.itv_us  <= clamp_us(itv_in);
            cfg_q.filt_en <= en_in;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/therm_interval_timer.sv
module therm_interval_timer
    import therm_pkg::*;
#(
    parameter int CYC_PER_US = 200,
    parameter int CNT_W      = $clog2(MAX_US * CYC_PER_US)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [US_W-1:0] itv_us,
    input  logic            accept,
    output logic            req_o,
    output logic            busy_o
);
    localparam logic [CNT_W-1:0] RST_LIMIT = CNT_W'(MIN_US * CYC_PER_US - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] next_limit;
    logic             req_q;
    logic             busy_q;

    assign next_limit = CNT_W'(int'(itv_us) * CYC_PER_US - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            limit_q <= RST_LIMIT;
            req_q   <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (accept)
                busy_q <= 1'b0;
            if (cnt_q == limit_q) begin
                // expired: hold here until the pending sample returns
                if (!busy_q) begin
                    req_q   <= 1'b1;
                    busy_q  <= 1'b1;
                    cnt_q   <= '0;
                    limit_q <= next_limit;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign req_o  = req_q;
    assign busy_o = busy_q;
endmodule

// File: rtl/therm_avg_filter.sv
module therm_avg_filter
    import therm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  filt_en,
    input  logic  accept,
    input  temp_t raw,
    output temp_t temp_o
);
    temp_t acc_q;
    logic  primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            primed_q <= 1'b0;
        end else begin
            if (!filt_en)
                primed_q <= 1'b0;
            if (accept) begin
                if (!filt_en) begin
                    acc_q <= raw;
                end else if (!primed_q) begin
                    acc_q    <= raw;
                    primed_q <= 1'b1;
                end else begin
                    acc_q <= half_blend(acc_q, raw);
                end
            end
        end
    end

    assign temp_o = acc_q;
endmodule

// File: rtl/therm_sample_sched.sv
module therm_sample_sched
    import therm_pkg::*;
#(
    parameter int CLK_HZ = 200_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [15:0] cfg_itv_us,
    input  logic        cfg_filt_en,
    output logic        sens_req,
    input  logic        sens_valid,
    input  logic [15:0] sens_temp,
    input  logic        host_rd,
    output logic [15:0] temp_out,
    output logic        fresh
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int CNT_W      = $clog2(MAX_US * CYC_PER_US);

    sched_cfg_t cfg;
    logic       busy;
    logic       accept;
    logic       filt_en_w;
    temp_t      filt_out;
    logic       fresh_q;

    therm_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .itv_in (cfg_itv_us),
        .en_in  (cfg_filt_en),
        .cfg_o  (cfg)
    );

    therm_interval_timer #(
        .CYC_PER_US (CYC_PER_US),
        .CNT_W      (CNT_W)
    ) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .itv_us (cfg.itv_us),
        .accept (accept),
        .req_o  (sens_req),
        .busy_o (busy)
    );

    assign accept    = sens_valid && busy;
    assign filt_en_w = cfg.filt_en;

    therm_avg_filter u_flt (
        .clk     (clk),
        .rst     (rst),
        .filt_en (filt_en_w),
        .accept  (accept),
        .raw     (temp_t'(sens_temp)),
        .temp_o  (filt_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            fresh_q <= 1'b0;
        else if (accept)
            fresh_q <= 1'b1;
        else if (host_rd)
            fresh_q <= 1'b0;
    end

    assign temp_out = filt_out;
    assign fresh    = fresh_q;
endmodule

// File: rtl/therm_sample_sched_chk.sv
module therm_sample_sched_chk (
    input logic        clk,
    input logic        rst,
    input logic        sens_req,
    input logic        sens_valid,
    input logic [15:0] sens_temp,
    input logic        host_rd,
    input logic [15:0] temp_out,
    input logic        fresh,
    input logic        filt_en_w
);
    logic pend;
    logic acc;

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (sens_req)
            pend <= 1'b1;
        else if (sens_valid)
            pend <= 1'b0;
    end

    assign acc = sens_valid && pend;

    p_req_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        sens_req |=> !sens_req);

    p_no_req_pending_r4: assert property (@(posedge clk) disable iff (rst)
        sens_req |-> !pend);

    p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
        (acc && !filt_en_w) |=> (temp_out == $past(sens_temp)));

    p_fresh_set_r9: assert property (@(posedge clk) disable iff (rst)
        acc |=> fresh);

    p_fresh_clr_r9: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !acc) |=> !fresh);

    p_ignore_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (sens_valid && !pend) |=> $stable(temp_out));
endmodule

bind therm_sample_sched therm_sample_sched_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sens_req   (sens_req),
    .sens_valid (sens_valid),
    .sens_temp  (sens_temp),
    .host_rd    (host_rd),
    .temp_out   (temp_out),
    .fresh      (fresh),
    .filt_en_w  (filt_en_w)
);

// File: tb/sim_therm_sample_sched.sv
`timescale 1ns/1ps
module sim_therm_sample_sched;
    localparam int HZ = 1_000_000;   // one cycle per microsecond

    typedef struct {
        int    v;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_itv_us = 16'd0;
    logic        cfg_filt_en = 1'b0;
    logic        sens_req;
    logic        sens_valid = 1'b0;
    logic [15:0] sens_temp = 16'd0;
    logic        host_rd = 1'b0;
    logic [15:0] temp_out;
    logic        fresh;

    always #2.5 clk = ~clk;

    therm_sample_sched #(.CLK_HZ(HZ)) u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_itv_us(cfg_itv_us),
        .cfg_filt_en(cfg_filt_en), .sens_req(sens_req), .sens_valid(sens_valid),
        .sens_temp(sens_temp), .host_rd(host_rd), .temp_out(temp_out), .fresh(fresh)
    );

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    exp_t exp_q[$];
    int   req_q[$];
    bit   pend     = 0;
    bit   prev_req = 0;
    bit   fresh_d  = 0;
    int   last_req = 0;
    int   m_val    = 0;
    bit   m_en     = 1;
    bit   m_primed = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // request observer: spacing source and pending rule
    always @(negedge clk) begin
        if (!rst) begin
            if (sens_req) begin
                checks++;
                if (pend) begin
                    fails++;
                    $display("FAIL R4 request while pending actual=1 expected=0");
                end
                if (prev_req) begin
                    fails++;
                    $display("FAIL R2 request wider than one cycle actual=2 expected=1");
                end
                req_q.push_back(cyc);
                pend = 1;
            end
            prev_req = sens_req;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst) begin
            fresh_d = 0;
        end else begin
            if (fresh && !fresh_d) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R10 unexpected update", $signed(temp_out), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk($signed(temp_out) == e.v, e.tag, $signed(temp_out), e.v);
                end
            end
            fresh_d = fresh;
        end
    end

    task automatic cfgw(input int us, input bit en);
        @(negedge clk);
        cfg_wr = 1; cfg_itv_us = 16'(us); cfg_filt_en = en;
        @(negedge clk);
        cfg_wr = 0;
        m_en = en;
        if (!en) m_primed = 0;
    endtask

    task automatic serve(input int raw, input int lat, input int exp_itv,
                         input bit rd_same, input string tag);
        int t;
        int e;
        exp_t item;
        wait (req_q.size() > 0);
        t = req_q.pop_front();
        if (exp_itv > 0)
            chk(t - last_req == exp_itv, "R2/R3/R4/R5 interval", t - last_req, exp_itv);
        last_req = t;
        while (cyc < t + lat - 1) @(negedge clk);
        if (!m_en) begin
            e = raw; m_primed = 0;
        end else if (!m_primed) begin
            e = raw; m_primed = 1;
        end else begin
            e = (m_val + raw) >>> 1;
        end
        m_val = e;
        item.v = e; item.tag = tag;
        exp_q.push_back(item);
        sens_valid = 1; sens_temp = 16'(raw); host_rd = rd_same; pend = 0;
        @(negedge clk);
        sens_valid = 0; host_rd = 0;
        if (rd_same) chk(fresh == 1, "R9 update wins over read", fresh, 1);
        host_rd = 1;
        @(negedge clk);
        host_rd = 0;
        chk(fresh == 0, "R9 read clears fresh", fresh, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        chk(sens_req == 0, "R1 req after reset", sens_req, 0);
        chk(fresh == 0, "R1 fresh after reset", fresh, 0);
        chk(temp_out == 0, "R1 temp after reset", $signed(temp_out), 0);

        serve(100, 3, -1, 0, "R7 first load");
        serve(60, 3, 82, 0, "R1 R6 average");
        serve(-3, 3, 82, 0, "R6 mixed sign");
        serve(-3, 3, 82, 0, "R6 odd sum");
        serve(-40, 3, 82, 0, "R6 floor negative");
        serve(32767, 3, 82, 0, "R6 full scale");
        serve(32767, 3, 82, 0, "R6 no overflow");
        serve(32767, 3, 82, 0, "R6 no overflow 2");

        // stray strobe with nothing pending
        @(negedge clk);
        sens_valid = 1; sens_temp = 16'd9999;
        @(negedge clk);
        sens_valid = 0;
        @(negedge clk);
        chk(fresh == 0, "R10 stray valid fresh", fresh, 0);
        chk($signed(temp_out) == m_val, "R10 stray valid temp", $signed(temp_out), m_val);

        cfgw(82, 0);
        serve(-32768, 3, 82, 0, "R8 bypass min");
        serve(5, 3, 82, 0, "R8 bypass");
        cfgw(82, 1);
        serve(1000, 3, 82, 0, "R7 reload after enable");
        serve(0, 3, 82, 0, "R6 after reload");
        serve(600, 3, 82, 1, "R9 same-cycle value");

        serve(7, 150, 82, 0, "R4 slow sensor");
        serve(8, 10, 151, 0, "R4 after stall");
        serve(9, 3, 82, 0, "R4 resumed");

        cfgw(100, 1);
        serve(11, 3, 82, 0, "R5 old interval kept");
        serve(12, 3, 100, 0, "R5 new interval");
        cfgw(10, 1);
        serve(13, 3, 100, 0, "R5 pending low");
        serve(14, 3, 82, 0, "R3 low clamp");
        cfgw(60000, 1);
        serve(15, 3, 82, 0, "R3 pending high");
        serve(16, 3, 20000, 0, "R3 high clamp");
        cfgw(82, 1);
        serve(17, 3, 20000, 0, "R5 restore pending");
        serve(18, 3, 82, 0, "R2 restored");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all updates seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule